// File: doc/BRIEF.md
# PWM Cycle-by-Cycle Overcurrent Gate

This block sits between a PWM source and a gate driver. While it is armed, the PWM waveform passes to the driver, delayed by its input synchronizer. When an overcurrent comparator reports a fault, the output is forced low for the rest of that PWM period. Clearing the fault does not bring the output back. The gate re-arms only on the next clean rising PWM edge, and that edge must arrive while the comparator is quiet.

Both inputs are asynchronous to the fast system clock, so each one passes through a flip-flop synchronizer first. The comparator signal may be glitchy, so it also goes through a consecutive-sample filter before it can blank the output. A control machine with two states (passing, blanked) drives the output multiplexer. A tracker holds the last seen PWM level and supplies the rising-edge strobe. A one-clock status pulse marks each trip from passing to blanked.

Top module: `pwm_trip_gate`

## Requirements
- R1: While `rstN` is low, `pwmOut` and `tripPulse` are 0. After reset is released, `pwmOut` stays 0 even if `pwmIn` is already high, until the first rising edge of `pwmIn` seen after reset.
- R2: While armed and with no fault, `pwmOut` equals `pwmIn` delayed by exactly 2 clocks, with the default 2-stage synchronizer.
- R3: A fault held high for at least FILT_LEN samples (default 2) drives `pwmOut` to 0 within 3 clocks of the fault edge.
- R4: A fault high for a single synchronized sample does not change `pwmOut`.
- R5: Once blanked, `pwmOut` stays 0 after the fault clears, including while `pwmIn` is still high. It follows `pwmIn` again from the next low-to-high transition of `pwmIn`, and that edge appears at the output 2 clocks after it occurs at the input.
- R6: A rising PWM edge that arrives while the fault is still high does not re-arm the gate, and the output stays 0 for that whole pulse.
- R7: If `pwmIn` and `faultIn` rise in the same clock while the gate is blanked, the fault wins and the gate stays blanked.
- R8: `tripPulse` is high for exactly one clock, 4 clocks after the fault edge, each time a fault moves the gate from passing to blanked. A fault that arrives while the gate is already blanked gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the PWM rate |
| rstN | input | 1 | Asynchronous reset, active low |
| pwmIn | input | 1 | Raw PWM from the modulator, asynchronous |
| faultIn | input | 1 | Overcurrent comparator output, asynchronous and possibly glitchy |
| pwmOut | output | 1 | Gated PWM to the driver |
| tripPulse | output | 1 | One-clock pulse on each passing-to-blanked trip |

## Verification
Delays are counted from the clock edge that first captures an input change. In that count, PWM edges reach `pwmOut` on the 2nd edge, a held fault blanks it on the 3rd edge, and `tripPulse` shows on the 4th edge. The bench changes inputs on falling clock edges and reads outputs one falling edge after each rising edge. Each table row therefore holds the value due after that many rising edges. Each row's expected value was worked out from these delays.

// File: rtl/trip_gate_pkg.sv
package trip_gate_pkg;

  typedef enum logic {
    GATE_BLANK = 1'b0,
    GATE_PASS  = 1'b1
  } gate_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic passSel;  // output mux selects PWM when high, else constant 0
    logic tripHit;  // passing state meets a filtered fault this cycle
  } gate_strobe_t;

endpackage

// File: rtl/trip_gate_dp.sv
module trip_gate_dp
  import trip_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         pwmIn,
  input  logic         faultIn,
  input  gate_strobe_t strobe,
  output logic         pwmRise,
  output logic         faultSync,
  output logic         faultFilt,
  output logic         gateOut,
  output logic         tripFlag
);

  logic [SYNC_STAGES-1:0] pwmSh;
  logic [SYNC_STAGES-1:0] faultSh;
  logic                   pwmSync;
  logic                   pwmWasHigh;

  // PWM chain resets high so a level held through reset is not an edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmSh      <= '1;
      faultSh    <= '0;
      pwmWasHigh <= 1'b1;
    end else begin
      pwmSh      <= {pwmSh[SYNC_STAGES-2:0], pwmIn};
      faultSh    <= {faultSh[SYNC_STAGES-2:0], faultIn};
      pwmWasHigh <= pwmSync;
    end
  end

  assign pwmSync   = pwmSh[SYNC_STAGES-1];
  assign faultSync = faultSh[SYNC_STAGES-1];
  assign pwmRise   = pwmSync && !pwmWasHigh;

  generate
    if (FILT_LEN <= 1) begin : gNoFilt
      assign faultFilt = faultSync;
    end else begin : gFilt
      localparam int CW = $clog2(FILT_LEN);
      localparam logic [CW-1:0] CNT_TOP = CW'(FILT_LEN - 1);
      logic [CW-1:0] hiCnt;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              hiCnt <= '0;
        else if (!faultSync)    hiCnt <= '0;
        else if (hiCnt != CNT_TOP) hiCnt <= hiCnt + 1'b1;
      end

      assign faultFilt = faultSync && (hiCnt == CNT_TOP);

      AST_FAULT_FILTERED: assert property (@(posedge clk) disable iff (!rstN)
        faultFilt |-> $past(faultSync)); // R4
    end
  endgenerate

  // output mux: PWM or constant zero
  assign gateOut = strobe.passSel ? pwmSync : 1'b0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tripFlag <= 1'b0;
    else       tripFlag <= strobe.tripHit;
  end

  AST_FAULT_BLANKS: assert property (@(posedge clk) disable iff (!rstN)
    faultFilt |-> !gateOut); // R3

  AST_STATUS_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    tripFlag |=> !tripFlag); // R8

endmodule

// File: rtl/trip_gate_ctrl.sv
module trip_gate_ctrl
  import trip_gate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         pwmRise,
  input  logic         faultSync,
  input  logic         faultFilt,
  output gate_strobe_t strobe
);

  gate_state_e state;
  gate_state_e stateNext;
  logic        rearm;

  // re-arm needs a rising edge with the comparator quiet; fault wins ties
  assign rearm = (state == GATE_BLANK) && pwmRise && !faultSync;

  always_comb begin
    stateNext = state;
    unique case (state)
      GATE_PASS:  if (faultFilt) stateNext = GATE_BLANK;
      GATE_BLANK: if (rearm)     stateNext = GATE_PASS;
      default:    stateNext = GATE_BLANK;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= GATE_BLANK;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.passSel = ((state == GATE_PASS) || rearm) && !faultFilt;
    strobe.tripHit = (state == GATE_PASS) && faultFilt;
  end

  AST_ARMED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == GATE_PASS && !faultFilt) |=> state == GATE_PASS); // R2

  AST_TRIP_BLANKS: assert property (@(posedge clk) disable iff (!rstN)
    (state == GATE_PASS && faultFilt) |=> state == GATE_BLANK); // R3

  AST_BLANK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == GATE_BLANK && !pwmRise) |=> state == GATE_BLANK); // R5

  AST_FAULT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (state == GATE_BLANK && pwmRise && faultSync) |=> state == GATE_BLANK); // R7

endmodule

// File: rtl/pwm_trip_gate.sv
module pwm_trip_gate
  import trip_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwmIn,
  input  logic faultIn,
  output logic pwmOut,
  output logic tripPulse
);

  gate_strobe_t strobe;
  logic         pwmRise;
  logic         faultSync;
  logic         faultFilt;

  trip_gate_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .pwmIn    (pwmIn),
    .faultIn  (faultIn),
    .strobe   (strobe),
    .pwmRise  (pwmRise),
    .faultSync(faultSync),
    .faultFilt(faultFilt),
    .gateOut  (pwmOut),
    .tripFlag (tripPulse)
  );

  trip_gate_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .pwmRise  (pwmRise),
    .faultSync(faultSync),
    .faultFilt(faultFilt),
    .strobe   (strobe)
  );

endmodule

// File: tb/pwm_trip_gate_test.sv
module pwm_trip_gate_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwmIn = 1'b0;
  logic faultIn = 1'b0;
  logic pwmOut;
  logic tripPulse;
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pwm_trip_gate uut (
    .clk      (clk),
    .rstN     (rstN),
    .pwmIn    (pwmIn),
    .faultIn  (faultIn),
    .pwmOut   (pwmOut),
    .tripPulse(tripPulse)
  );

  // row: {pwm, fault, expected pwmOut, expected tripPulse, req number}
  // inputs of row i are applied at a falling edge, outputs checked one falling edge later
  localparam int NV = 39;
  localparam logic [7:0] VEC [NV] = '{
    {4'b0000, 4'd2},  // 0
    {4'b1000, 4'd2},  // 1
    {4'b1010, 4'd2},  // 2  R2 first edge, 2 clocks
    {4'b0010, 4'd2},  // 3
    {4'b0000, 4'd2},  // 4  R2 falling edge
    {4'b1000, 4'd2},  // 5
    {4'b1010, 4'd2},  // 6
    {4'b1110, 4'd3},  // 7  fault rises
    {4'b1110, 4'd3},  // 8
    {4'b1000, 4'd3},  // 9  R3 blanked 3 clocks after fault
    {4'b1001, 4'd8},  // 10 R8 trip pulse
    {4'b1000, 4'd8},  // 11 R8 single clock, R5 still low
    {4'b0000, 4'd5},  // 12
    {4'b0000, 4'd5},  // 13
    {4'b1000, 4'd5},  // 14
    {4'b1010, 4'd5},  // 15 R5 re-armed by fresh edge
    {4'b1110, 4'd4},  // 16 one-sample glitch
    {4'b1010, 4'd4},  // 17
    {4'b1010, 4'd4},  // 18 R4 no effect
    {4'b0010, 4'd4},  // 19
    {4'b0000, 4'd2},  // 20
    {4'b1000, 4'd2},  // 21
    {4'b1110, 4'd2},  // 22
    {4'b1110, 4'd3},  // 23
    {4'b0100, 4'd3},  // 24 R3
    {4'b0101, 4'd8},  // 25 R8
    {4'b1100, 4'd8},  // 26 R8 no pulse while blanked
    {4'b1100, 4'd6},  // 27 R6 edge with fault high
    {4'b1000, 4'd6},  // 28
    {4'b0000, 4'd6},  // 29
    {4'b0000, 4'd6},  // 30
    {4'b0000, 4'd6},  // 31
    {4'b1100, 4'd7},  // 32 both rise together
    {4'b1000, 4'd7},  // 33 R7
    {4'b1000, 4'd7},  // 34 R7
    {4'b0000, 4'd7},  // 35
    {4'b0000, 4'd5},  // 36
    {4'b1000, 4'd5},  // 37
    {4'b1010, 4'd5}   // 38 R5
  };

  task automatic check(input logic got, input logic exp, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", what, got, exp, $time);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    pwmIn = VEC[0][7];
    faultIn = VEC[0][6];
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check(pwmOut, VEC[i][5], $sformatf("R%0d row %0d pwmOut", VEC[i][3:0], i));
      check(tripPulse, VEC[i][4], $sformatf("R%0d row %0d tripPulse", VEC[i][3:0], i));
      if (i + 1 < NV) begin
        pwmIn = VEC[i+1][7];
        faultIn = VEC[i+1][6];
      end
    end

    // R1: reset with PWM already high
    rstN = 1'b0;
    pwmIn = 1'b1;
    faultIn = 1'b0;
    repeat (3) @(negedge clk);
    check(pwmOut, 1'b0, "R1 output in reset");
    check(tripPulse, 1'b0, "R1 status in reset");
    rstN = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(pwmOut, 1'b0, "R1 held-high PWM after reset");
    end
    pwmIn = 1'b0;
    repeat (2) @(negedge clk);
    pwmIn = 1'b1;
    @(negedge clk);
    check(pwmOut, 1'b0, "R2 edge not yet through");
    @(negedge clk);
    check(pwmOut, 1'b1, "R1 first edge after reset arms");
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check(pwmOut, 1'b0, "R1 async reset clears output");
    rstN = 1'b1;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule